// File: doc/BRIEF.md
# Fault Alarm and Driver Shutdown Controller

This block gathers a ten-bit vector of fault flags from the rest of a sensor interpolator. It produces two results from that vector. The first is an open-drain style alarm pin drive, which either pulls the line low or releases it. The second is a request that turns the incremental line drivers off. Each result has its own ten-bit enable mask, so a fault can raise the alarm, stop the drivers, do both, or do neither.

Some event positions are not faults. Bit 6 and bit 9 are spare and are ignored on both paths. Bit 4 is shared, and its meaning depends on the path. On the alarm path it passes the raw index-enable input through, which makes the index window visible on the pin. On the shutdown path it stands for an outside device pulling the alarm line low. That outside pull-low only counts while polarity is 0 and while the block itself is releasing the line.

An alarm lasts at least a programmable minimum time. A 3-bit code selects code × 12.5 ms. The time is counted in `step_tick` pulses, with `TICKS_PER_STEP` pulses per 12.5 ms step. The default of 25 assumes a 0.5 ms tick. A polarity bit chooses the sense of the pin: with 0 the pin is pulled low on a fault, and with 1 it is pulled low while there is no fault.

Top module: `fault_alarm_ctrl`

## Requirements
- R1: While `rst_n` is low, the alarm is inactive and `shutdown_req` is 0. `pin_drive_low` then equals `pol_inv`.
- R2: An event on bit 0, 1, 2, 3, 5, 7 or 8 activates the alarm one clock edge later when the same bit of `alarm_mask` is 1. When that mask bit is 0, the event has no effect on the alarm.
- R3: On the alarm path, bit 4 of `alarm_mask` selects `idx_en_raw` as the source. The value of `events[4]` is not used by the alarm.
- R4: Event bits 6 and 9 have no effect on either the alarm or `shutdown_req`.
- R5: With `pol_inv` = 0, `pin_drive_low` is 1 while the alarm is active and 0 otherwise.
- R6: With `pol_inv` = 1, `pin_drive_low` is 0 while the alarm is active and 1 otherwise.
- R7: When no masked alarm source remains, the alarm stays active until `hold_code` × `TICKS_PER_STEP` ticks have been counted since the counter was last loaded. It clears on the edge after the tick that completes the count. With code 0 it clears on the first edge with no source. No count is taken on edges where `step_tick` is 0.
- R8: Every rising masked alarm source reloads the hold count. This includes a rise on the same edge at which the count would have expired.
- R9: `shutdown_req` is the OR of the events enabled by `shut_mask` (bits 0, 1, 2, 3, 5, 7 and 8), registered once. It is level-sensitive, so it falls one edge after the last enabled event falls.
- R10: Bit 4 of `shut_mask` enables the outside pull-low source: `pin_sensed_low` = 1 while `pin_drive_low` = 0 and `pol_inv` = 0. When `pol_inv` = 1, this source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | Time-base pulse; TICKS_PER_STEP pulses make 12.5 ms |
| events | input | 10 | Fault flags; bits 6 and 9 spare |
| alarm_mask | input | 10 | Enables for the alarm path |
| shut_mask | input | 10 | Enables for the driver shutdown path |
| pol_inv | input | 1 | Alarm pin polarity select |
| hold_code | input | 3 | Minimum alarm time in 12.5 ms steps |
| idx_en_raw | input | 1 | Raw index-enable signal for alarm bit 4 |
| pin_sensed_low | input | 1 | Alarm line sensed low |
| pin_drive_low | output | 1 | 1 pulls the alarm line low, 0 releases it |
| shutdown_req | output | 1 | Request to turn the line drivers off |

## Verification
Two of the block's functions can act on the same clock edge: the hold counter reaching zero and a fresh rising alarm source reloading it. The bench provokes this by raising a second masked event exactly on the edge where the count from the first event would expire. It then checks that the alarm holds for a full new period and clears on the edge after that period's last tick. A second case sets one fault bit in both masks, so the alarm and the shutdown act in the same cycle. The bench confirms that each of the two outputs still follows only its own mask and timing.

// File: rtl/fault_alarm_ctrl.sv
module fault_alarm_ctrl #(
  parameter int EVT_W = 10,
  parameter int HOLD_W = 3,
  parameter int TICKS_PER_STEP = 25,
  parameter int SHARED_BIT = 4,
  parameter logic [EVT_W-1:0] LIVE_MASK = 10'h1BF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_tick,
  input  logic [EVT_W-1:0] events,
  input  logic [EVT_W-1:0] alarm_mask,
  input  logic [EVT_W-1:0] shut_mask,
  input  logic             pol_inv,
  input  logic [HOLD_W-1:0] hold_code,
  input  logic             idx_en_raw,
  input  logic             pin_sensed_low,
  output logic             pin_drive_low,
  output logic             shutdown_req
);

  localparam int CNT_MAX = ((1 << HOLD_W) - 1) * TICKS_PER_STEP;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [EVT_W-1:0] alarm_src, alarm_src_q, shut_src;
  logic [CNT_W-1:0] hold_cnt, load_val;
  logic alarm_q, alarm_any, alarm_rise, ext_low;

  assign ext_low = pin_sensed_low & ~pin_drive_low & ~pol_inv;

  always_comb begin
    alarm_src = events & LIVE_MASK;
    alarm_src[SHARED_BIT] = idx_en_raw;
    alarm_src = alarm_src & alarm_mask;
    shut_src = events & LIVE_MASK;
    shut_src[SHARED_BIT] = ext_low;
    shut_src = shut_src & shut_mask;
  end

  assign alarm_any  = |alarm_src;
  assign alarm_rise = |(alarm_src & ~alarm_src_q);
  assign load_val   = CNT_W'(hold_code * TICKS_PER_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_src_q <= '0;
      hold_cnt <= '0;
      alarm_q <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      alarm_src_q <= alarm_src;
      if (alarm_rise)
        hold_cnt <= load_val;
      else if (step_tick && hold_cnt != '0)
        hold_cnt <= hold_cnt - CNT_W'(1);
      alarm_q <= alarm_any | (alarm_q & (hold_cnt != '0));
      shutdown_req <= |shut_src;
    end
  end

  assign pin_drive_low = alarm_q ^ pol_inv;

endmodule

module fault_alarm_ctrl_chk #(
  parameter int EVT_W = 10,
  parameter int CNT_W = 8,
  parameter int SHARED_BIT = 4,
  parameter logic [EVT_W-1:0] LIVE_MASK = 10'h1BF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] events,
  input logic [EVT_W-1:0] alarm_mask,
  input logic [EVT_W-1:0] shut_mask,
  input logic             pol_inv,
  input logic             pin_drive_low,
  input logic             shutdown_req,
  input logic             alarm_q,
  input logic             alarm_any,
  input logic [CNT_W-1:0] hold_cnt
);

  localparam logic [EVT_W-1:0] PLAIN = LIVE_MASK & ~(EVT_W'(1) << SHARED_BIT);

  logic shut_hit, alarm_hit;
  assign shut_hit  = |(events & shut_mask & PLAIN);
  assign alarm_hit = |(events & alarm_mask & PLAIN);

  assert_shut_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shut_hit |=> shutdown_req);

  assert_spare_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_hit && !shut_mask[SHARED_BIT]) |=> !shutdown_req);

  assert_pull_low_pol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_inv && !shut_hit) |=> !shutdown_req);

  assert_pol_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_inv && alarm_hit) |=> (pin_drive_low || pol_inv));

  assert_pol_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_inv && alarm_hit) |=> (!pin_drive_low || !pol_inv));

  assert_hold_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_q) |-> ($past(hold_cnt) == '0 && !$past(alarm_any)));

endmodule

bind fault_alarm_ctrl fault_alarm_ctrl_chk #(
  .EVT_W(EVT_W), .CNT_W(CNT_W), .SHARED_BIT(SHARED_BIT), .LIVE_MASK(LIVE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .events(events), .alarm_mask(alarm_mask),
  .shut_mask(shut_mask), .pol_inv(pol_inv), .pin_drive_low(pin_drive_low),
  .shutdown_req(shutdown_req), .alarm_q(alarm_q), .alarm_any(alarm_any),
  .hold_cnt(hold_cnt)
);

// File: tb/fault_alarm_ctrl_bench.sv
module fault_alarm_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_tick = 1'b0;
  logic [9:0] events = '0, alarm_mask = '0, shut_mask = '0;
  logic pol_inv = 1'b0;
  logic [2:0] hold_code = '0;
  logic idx_en_raw = 1'b0, pin_sensed_low = 1'b0;
  logic pin_drive_low, shutdown_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_alarm_ctrl u_fault_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .events(events),
    .alarm_mask(alarm_mask), .shut_mask(shut_mask), .pol_inv(pol_inv),
    .hold_code(hold_code), .idx_en_raw(idx_en_raw),
    .pin_sensed_low(pin_sensed_low), .pin_drive_low(pin_drive_low),
    .shutdown_req(shutdown_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    events = '0; alarm_mask = '0; shut_mask = '0; pol_inv = 1'b0;
    hold_code = '0; idx_en_raw = 1'b0; pin_sensed_low = 1'b0; step_tick = 1'b1;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1 pin in reset", pin_drive_low, 1'b0);
    chk("R1 shutdown in reset", shutdown_req, 1'b0);
    pol_inv = 1'b1; #1;
    chk("R1 pin in reset pol1", pin_drive_low, 1'b1);
    events = 10'h3FF; alarm_mask = 10'h3FF; shut_mask = 10'h3FF;
    step();
    chk("R1 shutdown held in reset", shutdown_req, 1'b0);
    chk("R1 alarm held in reset", pin_drive_low, 1'b1);
    events = '0; alarm_mask = '0; shut_mask = '0; pol_inv = 1'b0;
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_alarm_map();
    int bits[7] = '{0, 1, 2, 3, 5, 7, 8};
    foreach (bits[k]) begin
      alarm_mask = 10'(1 << bits[k]); events = 10'(1 << bits[k]);
      step();
      chk("R2 enabled bit raises alarm", pin_drive_low, 1'b1);
      events = '0;
      step();
      chk("R2 alarm clears code 0", pin_drive_low, 1'b0);
      alarm_mask = ~10'(1 << bits[k]) & ~10'h010; events = 10'(1 << bits[k]);
      step();
      chk("R2 masked-off bit ignored", pin_drive_low, 1'b0);
      events = '0;
      step();
    end
  endtask

  task automatic t_index();
    alarm_mask = 10'h010; idx_en_raw = 1'b1;
    step();
    chk("R3 index enable raises alarm", pin_drive_low, 1'b1);
    idx_en_raw = 1'b0; events = 10'h010;
    step();
    chk("R3 event bit 4 ignored by alarm", pin_drive_low, 1'b0);
    idle();
  endtask

  task automatic t_spare();
    alarm_mask = 10'h3FF; shut_mask = 10'h3EF; events = 10'h240;
    step(); step();
    chk("R4 spare bits no alarm", pin_drive_low, 1'b0);
    chk("R4 spare bits no shutdown", shutdown_req, 1'b0);
    idle();
  endtask

  task automatic t_polarity();
    pol_inv = 1'b1; #1;
    chk("R6 pol1 idle drives low", pin_drive_low, 1'b1);
    alarm_mask = 10'h002; events = 10'h002;
    step();
    chk("R6 pol1 alarm releases", pin_drive_low, 1'b0);
    events = '0;
    step();
    chk("R6 pol1 back to low", pin_drive_low, 1'b1);
    pol_inv = 1'b0; #1;
    chk("R5 pol0 idle released", pin_drive_low, 1'b0);
    events = 10'h002;
    step(); step(); step();
    chk("R5 pol0 held event stays low", pin_drive_low, 1'b1);
    idle();
  endtask

  task automatic t_hold();
    hold_code = 3'd2; alarm_mask = 10'h001; events = 10'h001; step_tick = 1'b1;
    step();
    chk("R7 alarm set", pin_drive_low, 1'b1);
    events = '0;
    for (int j = 1; j <= 2*TPS; j++) begin
      step();
      chk("R7 alarm held within window", pin_drive_low, 1'b1);
    end
    step();
    chk("R7 alarm clears after window", pin_drive_low, 1'b0);
    hold_code = 3'd1; step_tick = 1'b0; events = 10'h001;
    step();
    events = '0;
    for (int j = 0; j < 40; j++) step();
    chk("R7 no count without tick", pin_drive_low, 1'b1);
    step_tick = 1'b1;
    for (int j = 1; j <= TPS; j++) step();
    chk("R7 last tick still held", pin_drive_low, 1'b1);
    step();
    chk("R7 clears after ticks", pin_drive_low, 1'b0);
    idle();
  endtask

  task automatic t_reload();
    hold_code = 3'd1; alarm_mask = 10'h003; step_tick = 1'b1;
    events = 10'h001;
    step();
    events = '0;
    for (int j = 1; j <= 9; j++) step();
    events = 10'h002;
    step();
    events = '0;
    for (int j = 1; j <= 20; j++) step();
    chk("R8 reload extends past first window", pin_drive_low, 1'b1);
    for (int j = 21; j <= TPS; j++) step();
    chk("R8 held to end of reloaded window", pin_drive_low, 1'b1);
    step();
    chk("R8 clears after reloaded window", pin_drive_low, 1'b0);
    idle();
    hold_code = 3'd1; alarm_mask = 10'h003;
    events = 10'h001;
    step();
    events = '0;
    for (int j = 1; j <= TPS - 1; j++) step();
    events = 10'h002;
    step();
    events = '0;
    for (int j = 1; j <= TPS; j++) step();
    chk("R8 reload beats expiry same edge", pin_drive_low, 1'b1);
    step();
    chk("R8 clears after coincident reload", pin_drive_low, 1'b0);
    idle();
  endtask

  task automatic t_shutdown();
    shut_mask = 10'h088; alarm_mask = 10'h001; events = 10'h080;
    #1;
    chk("R9 shutdown registered not yet", shutdown_req, 1'b0);
    step();
    chk("R9 shutdown follows event", shutdown_req, 1'b1);
    chk("R9 alarm path untouched", pin_drive_low, 1'b0);
    events = 10'h089;
    step();
    chk("R9 shared fault shutdown", shutdown_req, 1'b1);
    chk("R2 shared fault alarm", pin_drive_low, 1'b1);
    events = 10'h001;
    step();
    chk("R9 shutdown falls with events", shutdown_req, 1'b0);
    events = 10'h004;
    step();
    chk("R9 unmasked event no shutdown", shutdown_req, 1'b0);
    idle();
  endtask

  task automatic t_pull_low();
    shut_mask = 10'h010; pin_sensed_low = 1'b1;
    step();
    chk("R10 pol0 outside pull-low shuts down", shutdown_req, 1'b1);
    events = 10'h010;
    pin_sensed_low = 1'b0;
    step();
    chk("R10 event bit 4 not used for shutdown", shutdown_req, 1'b0);
    events = '0;
    pol_inv = 1'b1; pin_sensed_low = 1'b1;
    alarm_mask = 10'h001; events = 10'h001;
    step(); step();
    chk("R10 pol1 pull-low ignored", shutdown_req, 1'b0);
    pol_inv = 1'b0;
    step();
    chk("R10 own drive not outside pull-low", shutdown_req, 1'b0);
    idle();
  endtask

  initial begin
    step(); step();
    t_reset();
    idle();
    t_alarm_map();
    t_index();
    t_spare();
    t_polarity();
    t_hold();
    t_reload();
    t_shutdown();
    t_pull_low();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule